// File: doc/BRIEF.md
# FIFO-Watermark Serial Port Control Core

This block is the register-side core of a simple byte-wide serial port. A processor reaches it through a 32-bit read/write port with word-aligned byte offsets. Bytes written to the transmit data word enter an eight-entry transmit queue. The line-side serialiser takes them out through a byte handshake. The line-side deserialiser pushes received bytes into an eight-entry receive queue, and the processor drains that queue by reading the receive data word. Each data word returns a status flag in bit 31 together with the data.

The core also holds the line configuration and drives it out as plain outputs: the bit-period divisor, the stop-bit selection and the two direction enables. Interrupts come only from queue levels. Each queue has a 3-bit watermark count. A pending bit is derived from the live occupancy, and the single interrupt output is the OR of the pending bits that are enabled. There is no source-priority scheme and no clear-on-read.

The core has no sequencing beyond the queues. Register access completes in one cycle, with read data registered on the access edge. The only state that changes with traffic is the two queue pointers and their occupancy counters.

Top module: `uwm_core`

## Requirements
- R1: After reset both queues are empty; the enables, stop selection, interrupt enables, watermark counts and divisor are all 0; `irq` and `tx_avail` are 0. A read of offset 0x4 returns 0x80000000, and a read of offset 0x8 returns 0.
- R2: A write to offset 0x0 appends bits [7:0] of the write data to the transmit queue. A read of offset 0x0 returns bit 31 set exactly when the queue holds 8 bytes, with all other bits 0. A write while the queue is full is dropped.
- R3: `tx_avail` is 1 only when transmit is enabled and the transmit queue is non-empty, and `tx_byte` then shows the oldest byte. A cycle with `tx_take` and `tx_avail` both high removes that byte, so bytes leave in the order they were written.
- R4: A read of offset 0x4 returns the oldest received byte in bits [7:0] with bit 31 clear, and removes that byte. When the receive queue is empty, the read returns 0x80000000 and removes nothing.
- R5: A byte presented with `rx_push` is discarded when receive is disabled or the receive queue already holds 8 bytes.
- R6: Offset 0x8 holds transmit enable in bit 0, the stop selection in bit 1 (0 = one stop bit, 1 = two), and the transmit watermark count in bits [18:16]. It reads back as written with the other bits 0, and bits 0 and 1 drive `tx_en` and `two_stop`.
- R7: Offset 0xC holds receive enable in bit 0 and the receive watermark count in bits [18:16]. It reads back as written with the other bits 0, and bit 0 drives `rx_en`.
- R8: Bit 0 of the pending word at offset 0x14 is 1 exactly when the transmit queue occupancy is strictly less than the transmit watermark count.
- R9: Bit 1 of the pending word at offset 0x14 is 1 exactly when the receive queue occupancy is strictly greater than the receive watermark count.
- R10: The pending word is read-only, and writes to offset 0x14 leave its value unchanged.
- R11: Offset 0x10 holds the interrupt enables, with the transmit watermark in bit 0 and the receive watermark in bit 1. `irq` is 1 exactly when some pending bit and its enable bit are both 1.
- R12: Offset 0x18 holds a 16-bit divisor in bits [15:0] that drives `baud_div`. One bit period lasts `baud_div` + 1 clocks, and the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the access edge |
| irq | output | 1 | Combined watermark interrupt |
| baud_div | output | 16 | Bit-period divisor |
| two_stop | output | 1 | Two stop bits selected |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| tx_byte | output | 8 | Oldest byte in the transmit queue |
| tx_avail | output | 1 | A byte is ready for the serialiser |
| tx_take | input | 1 | Serialiser accepts `tx_byte` |
| rx_byte | input | 8 | Received byte from the deserialiser |
| rx_push | input | 1 | Deserialiser strobe for `rx_byte` |

## Verification
The hardest conditions to reach are the queue limits while the watermarks sit at their extremes. One case is a full receive queue with a count of 7, the only setting where the receive pending bit needs all eight entries. Another is a transmit write or a receive push landing on a full queue in the same cycle as a removal on the other side. Directed sequences fill each queue to the limit and then push one more byte to reach these cases. A seeded random phase then interleaves writes, takes, pushes, reads and watermark reprogramming, while a bench-side queue model predicts every pending bit and the interrupt line.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int FLAG_BIT = 31;
    localparam int CNT_LSB  = 16;

    // word index of each register (byte offset / 4)
    typedef enum logic [2:0] {
        SEL_TXD  = 3'd0,
        SEL_RXD  = 3'd1,
        SEL_TXC  = 3'd2,
        SEL_RXC  = 3'd3,
        SEL_IE   = 3'd4,
        SEL_IP   = 3'd5,
        SEL_DIV  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/uwm_fifo.sv
module uwm_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/uwm_wm.sv
module uwm_wm #(
    parameter int LVL_W = 4,
    parameter int CNT_W = 3,
    parameter bit ABOVE = 1'b0
) (
    input  logic [LVL_W-1:0] level,
    input  logic [CNT_W-1:0] count,
    output logic             pend
);
    logic [LVL_W-1:0] cnt_ext;
    assign cnt_ext = LVL_W'(count);

    generate
        if (ABOVE) begin : g_above
            assign pend = (level > cnt_ext);
        end else begin : g_below
            assign pend = (level < cnt_ext);
        end
    endgenerate
endmodule

// File: rtl/uwm_core.sv
module uwm_core
    import uwm_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 3,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 5,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [DIV_W-1:0]  baud_div,
    output logic              two_stop,
    output logic              tx_en,
    output logic              rx_en,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              tx_take,
    input  logic [7:0]        rx_byte,
    input  logic              rx_push
);
    logic [IDX_W-1:0] widx;
    reg_sel_e         sel;
    logic             wr_acc, rd_acc;

    logic             tx_en_q, rx_en_q, two_stop_q;
    logic [CNT_W-1:0] tx_cnt_q, rx_cnt_q;
    logic [1:0]       ie_q;
    logic [DIV_W-1:0] div_q;

    logic [LVL_W-1:0] tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]       tx_head, rx_head;
    logic             tx_wpush, tx_lpop, rx_lpush, rx_rpop;
    logic             tx_pend, rx_pend;
    logic [1:0]       pend;
    logic [31:0]      rd_val;

    // address decode
    assign widx   = bus_addr[ADDR_W-1:2];
    assign sel    = (widx < IDX_W'(7)) ? reg_sel_e'(widx[2:0]) : SEL_NONE;
    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    // queue strobes
    assign tx_wpush = wr_acc && (sel == SEL_TXD);
    assign rx_rpop  = rd_acc && (sel == SEL_RXD);
    assign tx_avail = tx_en_q && !tx_empty;
    assign tx_lpop  = tx_take && tx_avail;
    assign rx_lpush = rx_push && rx_en_q;

    uwm_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wpush), .din(bus_wdata[7:0]),
        .pop(tx_lpop), .dout(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    uwm_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_lpush), .din(rx_byte),
        .pop(rx_rpop), .dout(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    uwm_wm #(.LVL_W(LVL_W), .CNT_W(CNT_W), .ABOVE(1'b0)) u_txwm (
        .level(tx_level), .count(tx_cnt_q), .pend(tx_pend)
    );

    uwm_wm #(.LVL_W(LVL_W), .CNT_W(CNT_W), .ABOVE(1'b1)) u_rxwm (
        .level(rx_level), .count(rx_cnt_q), .pend(rx_pend)
    );

    assign pend = {rx_pend, tx_pend};
    assign irq  = |(pend & ie_q);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q    <= 1'b0;
            two_stop_q <= 1'b0;
            tx_cnt_q   <= '0;
            rx_en_q    <= 1'b0;
            rx_cnt_q   <= '0;
            ie_q       <= '0;
            div_q      <= '0;
        end else if (wr_acc) begin
            unique case (sel)
                SEL_TXC: begin
                    tx_en_q    <= bus_wdata[0];
                    two_stop_q <= bus_wdata[1];
                    tx_cnt_q   <= bus_wdata[CNT_LSB +: CNT_W];
                end
                SEL_RXC: begin
                    rx_en_q  <= bus_wdata[0];
                    rx_cnt_q <= bus_wdata[CNT_LSB +: CNT_W];
                end
                SEL_IE:  ie_q  <= bus_wdata[1:0];
                SEL_DIV: div_q <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_TXD: rd_val[FLAG_BIT] = tx_full;
            SEL_RXD: begin
                rd_val[FLAG_BIT] = rx_empty;
                rd_val[7:0]      = rx_empty ? 8'h00 : rx_head;
            end
            SEL_TXC: begin
                rd_val[0] = tx_en_q;
                rd_val[1] = two_stop_q;
                rd_val[CNT_LSB +: CNT_W] = tx_cnt_q;
            end
            SEL_RXC: begin
                rd_val[0] = rx_en_q;
                rd_val[CNT_LSB +: CNT_W] = rx_cnt_q;
            end
            SEL_IE:  rd_val[1:0] = ie_q;
            SEL_IP:  rd_val[1:0] = pend;
            SEL_DIV: rd_val[DIV_W-1:0] = div_q;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_val;
    end

    assign baud_div = div_q;
    assign two_stop = two_stop_q;
    assign tx_en    = tx_en_q;
    assign rx_en    = rx_en_q;
    assign tx_byte  = tx_head;
endmodule

// File: rtl/uwm_chk.sv
module uwm_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 5,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_take,
    input logic              tx_avail,
    input logic              tx_en,
    input logic              rx_push,
    input logic              rx_en,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic [1:0]        ie_q,
    input logic              irq
);
    logic tx_wr, rx_rd;
    assign tx_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign rx_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(4));

    // R2, R5: occupancy never exceeds the queue depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    // R2: a write into a full queue with no removal leaves it full
    a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_level == LVL_W'(DEPTH) && !(tx_take && tx_avail))
        |=> (tx_level == LVL_W'(DEPTH)));

    // R3: the serialiser only sees a byte when enabled and queued
    a_r3_avail_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tx_avail |-> (tx_en && tx_level != '0));

    // R4: reading an empty receive queue removes nothing
    a_r4_empty_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_level == '0 && !rx_push) |=> (rx_level == '0));

    // R5: with receive disabled the queue never grows
    a_r5_disabled_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (rx_level <= $past(rx_level)));

    // R11: the interrupt line needs at least one enable
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q != 2'b00));
endmodule

bind uwm_core uwm_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .tx_take(tx_take), .tx_avail(tx_avail), .tx_en(tx_en),
    .rx_push(rx_push), .rx_en(rx_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .ie_q(ie_q), .irq(irq)
);

// File: tb/test_uwm_core.sv
module test_uwm_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, two_stop, tx_en, rx_en, tx_avail;
    logic [15:0] baud_div;
    logic [7:0]  tx_byte;
    logic        tx_take = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_push = 1'b0;

    int total = 0;
    int bad   = 0;
    logic [31:0] rd;
    logic [7:0]  tb;

    // bench-side model
    logic [7:0] tq[$];
    logic [7:0] rq[$];
    int  m_txcnt, m_rxcnt;
    bit  m_txen, m_rxen;
    logic [1:0] m_ie;

    always #5 clk = ~clk;

    uwm_core i_uwm_core (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .baud_div(baud_div), .two_stop(two_stop),
        .tx_en(tx_en), .rx_en(rx_en),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_push(rx_push)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic take(output logic [7:0] b);
        @(negedge clk);
        b = tx_byte;
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    function automatic logic [1:0] exp_ip();
        return {(rq.size() > m_rxcnt), (tq.size() < m_txcnt)};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tq.delete(); rq.delete();
        m_txcnt = 0; m_rxcnt = 0; m_txen = 0; m_rxen = 0; m_ie = 2'b00;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
        summary();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 baud_div", 32'(baud_div), 0);
        chk("R1 enables", {29'b0, tx_en, rx_en, two_stop}, 0);
        chk("R1 tx_avail", 32'(tx_avail), 0);
        rdreg(5'h04, rd); chk("R1 rx empty word", rd, 32'h8000_0000);
        rdreg(5'h08, rd); chk("R1 txctrl", rd, 0);

        // R12 divisor
        wr(5'h18, 32'h1234_ABCD);
        chk("R12 baud_div", 32'(baud_div), 32'h0000_ABCD);
        rdreg(5'h18, rd); chk("R12 readback", rd, 32'h0000_ABCD);

        // R6 transmit control
        wr(5'h08, 32'hFFF5_FFFC | 32'h3);
        rdreg(5'h08, rd); chk("R6 readback", rd, 32'h0005_0003);
        chk("R6 outputs", {30'b0, tx_en, two_stop}, 32'h3);
        wr(5'h08, 32'h0001_0000);
        chk("R6 disable", {30'b0, tx_en, two_stop}, 0);

        // R3 gating and order
        wr(5'h00, 32'hFFFF_FF41);
        chk("R3 avail while disabled", 32'(tx_avail), 0);
        wr(5'h08, 32'h0001_0001);
        chk("R3 avail enabled", 32'(tx_avail), 1);
        take(tb); chk("R3 byte", 32'(tb), 32'h41);
        chk("R3 drained", 32'(tx_avail), 0);

        // R2 full flag and drop
        for (int i = 0; i < 8; i++) wr(5'h00, 32'h10 + i);
        rdreg(5'h00, rd); chk("R2 full flag", rd, 32'h8000_0000);
        wr(5'h00, 32'h18);
        for (int i = 0; i < 8; i++) begin
            take(tb); chk("R2/R3 drain order", 32'(tb), 32'h10 + i);
        end
        chk("R2 ninth dropped", 32'(tx_avail), 0);
        rdreg(5'h00, rd); chk("R2 not full", rd, 0);

        // R8 transmit watermark, count 1
        rdreg(5'h14, rd); chk("R8 empty pending", rd, 32'h1);
        wr(5'h00, 32'h55);
        rdreg(5'h14, rd); chk("R8 one byte not pending", rd, 0);
        take(tb);

        // R11 masking
        wr(5'h10, 32'h1);
        chk("R11 tx irq", 32'(irq), 1);
        wr(5'h10, 32'h0);
        chk("R11 masked", 32'(irq), 0);

        // R7, R4 receive path
        wr(5'h0C, 32'hFFF8_FFFF & 32'h0000_0001);
        rdreg(5'h0C, rd); chk("R7 readback", rd, 32'h1);
        chk("R7 rx_en", 32'(rx_en), 1);
        push(8'hA5);
        rdreg(5'h14, rd); chk("R9 count0 pending", rd, 32'h3);
        wr(5'h10, 32'h2);
        chk("R11 rx irq", 32'(irq), 1);
        rdreg(5'h04, rd); chk("R4 data", rd, 32'h0000_00A5);
        chk("R11 rx cleared", 32'(irq), 0);
        rdreg(5'h04, rd); chk("R4 empty read", rd, 32'h8000_0000);
        push(8'h3C);
        rdreg(5'h04, rd); chk("R4 no pop on empty", rd, 32'h0000_003C);

        // R5 disabled discard
        wr(5'h0C, 32'h0);
        push(8'h77);
        wr(5'h0C, 32'h1);
        rdreg(5'h04, rd); chk("R5 disabled discard", rd, 32'h8000_0000);

        // R5 full discard, R9 count 7
        wr(5'h0C, 32'h0007_0001);
        for (int i = 0; i < 8; i++) push(8'h30 + 8'(i));
        rdreg(5'h14, rd); chk("R9 full at count7", rd[1], 1'b1);
        push(8'h38);
        for (int i = 0; i < 8; i++) begin
            rdreg(5'h04, rd); chk("R5 full order", rd, 32'h30 + i);
        end
        rdreg(5'h04, rd); chk("R5 ninth discarded", rd, 32'h8000_0000);

        // R9 count 2 boundary
        wr(5'h0C, 32'h0002_0001);
        push(8'h01); push(8'h02);
        rdreg(5'h14, rd); chk("R9 at count", rd[1], 1'b0);
        push(8'h03);
        rdreg(5'h14, rd); chk("R9 above count", rd[1], 1'b1);

        // R10 read-only pending
        wr(5'h14, 32'hFFFF_FFFF);
        rdreg(5'h14, rd); chk("R10 write ignored", rd, 32'h3);

        // random phase
        do_reset();
        void'($urandom(32'd4242));
        for (int it = 0; it < 1500; it++) begin
            int op;
            op = int'($urandom_range(0, 7));
            case (op)
                0: begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    wr(5'h00, {24'b0, b});
                    if (tq.size() < 8) tq.push_back(b);
                end
                1: begin
                    bit exp_av;
                    exp_av = m_txen && tq.size() > 0;
                    chk("R3 rand avail", 32'(tx_avail), 32'(exp_av));
                    take(tb);
                    if (exp_av) begin
                        chk("R3 rand byte", 32'(tb), 32'(tq[0]));
                        void'(tq.pop_front());
                    end
                end
                2: begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    push(b);
                    if (m_rxen && rq.size() < 8) rq.push_back(b);
                end
                3: begin
                    rdreg(5'h04, rd);
                    if (rq.size() == 0) chk("R4 rand empty", rd, 32'h8000_0000);
                    else begin
                        chk("R4 rand data", rd, {24'b0, rq[0]});
                        void'(rq.pop_front());
                    end
                end
                4: begin
                    m_txcnt = int'($urandom_range(0, 7));
                    m_txen  = 1'b1;
                    wr(5'h08, (32'(m_txcnt) << 16) | 32'h1);
                end
                5: begin
                    m_rxcnt = int'($urandom_range(0, 7));
                    m_rxen  = ($urandom_range(0, 3) != 0);
                    wr(5'h0C, (32'(m_rxcnt) << 16) | 32'(m_rxen));
                end
                6: begin
                    m_ie = 2'($urandom);
                    wr(5'h10, {30'b0, m_ie});
                end
                default: begin
                    rdreg(5'h14, rd);
                    chk("R8/R9 rand pending", rd, {30'b0, exp_ip()});
                end
            endcase
            chk("R11 rand irq", 32'(irq), 32'(|(exp_ip() & m_ie)));
        end
        summary();
    end
endmodule